// File: doc/BRIEF.md
# Dual-Width Byte-Lane Static Memory

This block is a clocked, synthesizable model of a static memory array whose behaviour follows a set of control pins. Two chip selects (one active low, one active high), an active-low write strobe, an active-low output enable and two active-low byte-lane controls decide whether a cycle reads, writes or leaves the block idle. The bidirectional data bus is split into an input vector, an output vector and a per-bit drive-enable vector, which together stand in for tri-state pins.

An active-low width-select input chooses between two organisations of the same storage. In word mode the block holds 16-bit words, and each 8-bit lane is gated by its own lane control. In byte mode only the low eight data bits carry data. The top input data bit then becomes the least significant address bit and picks one half of the stored word. Writes are committed on the rising clock edge that ends a cycle with a valid write condition. Reads return data combinationally from the current address.

The control pins are plain levels with no handshake. The block accepts a write on every clock edge where the write condition holds and cannot apply back-pressure, so the driver must hold address, data and controls stable across that edge.

Top module: `dwsram`

## Requirements
- R1: A write is committed at a rising clock edge only when `wr_n`=0, `cs_a_n`=0, `cs_b`=1 and at least one lane control is low. In word mode lane 0 (`lane0_n`) gates bits 7:0 and lane 1 (`lane1_n`) gates bits 15:8 independently, and a disabled lane keeps its stored byte.
- R2: In word mode, with `wr_n`=1, `oe_n`=0 and both chip selects active, `dq_oe[7:0]` is all ones exactly when `lane0_n`=0 and `dq_oe[15:8]` is all ones exactly when `lane1_n`=0. The enabled lanes show the stored bytes on `dq_out`.
- R3: When `cs_a_n`=1, or `cs_b`=0, or both lane controls are high, `dq_oe` is zero and no write takes place.
- R4: When selected with `wr_n`=1 and `oe_n`=1, `dq_oe` is zero.
- R5: While `wr_n`=0, `dq_oe` is zero whatever the level of `oe_n`.
- R6: With `byte_mode_n`=0 (byte mode), `dq_in[15]` is an address bit: 0 selects bits 7:0 of the stored word and 1 selects bits 15:8. Reads appear on `dq_out[7:0]` with `dq_oe[7:0]` all ones. `dq_oe[15:8]` stays zero. Writes take data from `dq_in[7:0]` only and leave the other half of the word unchanged.
- R7: In byte mode the block is active only when both lane controls are low. With either lane control high it neither drives nor writes.
- R8: A read reflects a write from the clock edge just before it, and it follows a change of `addr` with no clock edge in between.
- R9: Every bit of `dq_out` whose `dq_oe` bit is zero reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst_n | input | 1 | Active-low reset; blocks writes while low |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| wr_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| lane0_n | input | 1 | Lane control for bits 7:0, active low |
| lane1_n | input | 1 | Lane control for bits 15:8, active low |
| byte_mode_n | input | 1 | Width select: low = byte mode, high = word mode |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Data bus input side; bit 15 is the extra address bit in byte mode |
| dq_out | output | 16 | Data bus output side |
| dq_oe | output | 16 | Per-bit drive enable for the data bus |

## Verification
On every cycle, the assertions check the drive-enable pattern against the pins. They confirm a silent bus under each of the three deselect conditions, during any write, when selected with output enable high, and in byte mode with a lane control high. They also check the upper byte in byte mode, the word-mode lane mapping, and the zero value of undriven output bits. Only the bench scenarios can show that storage really changed or stayed the same. This covers lane-masked writes, blocked writes under deselect, the way the half-word bit picks a half in byte mode, and read-after-write across one clock edge.

// File: rtl/dwsram_pkg.sv
package dwsram_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int BUS_W  = LANES * LANE_W;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_t;
endpackage

// File: rtl/dwsram_ctrl.sv
module dwsram_ctrl
  import dwsram_pkg::*;
(
  input  logic             cs_a_n,
  input  logic             cs_b,
  input  logic             wr_n,
  input  logic             oe_n,
  input  logic             lane0_n,
  input  logic             lane1_n,
  input  logic             byte_mode_n,
  input  logic             half_sel,
  output acc_t             acc,
  output logic [LANES-1:0] lane_en,
  output logic             narrow
);
  logic chip_on;
  logic active;

  always_comb begin
    narrow  = ~byte_mode_n;
    chip_on = ~cs_a_n & cs_b;
    // byte mode needs both lanes low; word mode needs any lane low
    if (narrow) begin
      active  = chip_on & ~lane0_n & ~lane1_n;
      lane_en = half_sel ? 2'b10 : 2'b01;
    end else begin
      active  = chip_on & (~lane0_n | ~lane1_n);
      lane_en = {~lane1_n, ~lane0_n};
    end
    if (!active)      acc = ACC_IDLE;
    else if (!wr_n)   acc = ACC_WRITE;
    else if (!oe_n)   acc = ACC_READ;
    else              acc = ACC_IDLE;
  end
endmodule

// File: rtl/dwsram_lane.sv
module dwsram_lane #(
  parameter int ADDR_W = 6,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
  end

  assign rdata = store[addr];
endmodule

// File: rtl/dwsram.sv
module dwsram
  import dwsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_a_n,
  input  logic              cs_b,
  input  logic              wr_n,
  input  logic              oe_n,
  input  logic              lane0_n,
  input  logic              lane1_n,
  input  logic              byte_mode_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dq_in,
  output logic [15:0]       dq_out,
  output logic [15:0]       dq_oe
);
  acc_t             acc;
  logic [LANES-1:0] lane_en;
  logic             narrow;
  logic [LANE_W-1:0] rd [LANES];

  dwsram_ctrl u_ctrl (
    .cs_a_n      (cs_a_n),
    .cs_b        (cs_b),
    .wr_n        (wr_n),
    .oe_n        (oe_n),
    .lane0_n     (lane0_n),
    .lane1_n     (lane1_n),
    .byte_mode_n (byte_mode_n),
    .half_sel    (dq_in[BUS_W-1]),
    .acc         (acc),
    .lane_en     (lane_en),
    .narrow      (narrow)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] wd;
    logic              we;
    assign wd = narrow ? dq_in[LANE_W-1:0] : dq_in[g*LANE_W +: LANE_W];
    assign we = rst_n & (acc == ACC_WRITE) & lane_en[g];
    dwsram_lane #(.ADDR_W(ADDR_W), .DW(LANE_W)) u_mem (
      .clk   (clk),
      .we    (we),
      .addr  (addr),
      .wdata (wd),
      .rdata (rd[g])
    );
  end

  always_comb begin
    dq_out = '0;
    dq_oe  = '0;
    if (acc == ACC_READ) begin
      if (narrow) begin
        dq_out[LANE_W-1:0] = lane_en[1] ? rd[1] : rd[0];
        dq_oe[LANE_W-1:0]  = '1;
      end else begin
        for (int i = 0; i < LANES; i++) begin
          if (lane_en[i]) begin
            dq_out[i*LANE_W +: LANE_W] = rd[i];
            dq_oe[i*LANE_W +: LANE_W]  = '1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dwsram_check.sv
module dwsram_check #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_a_n,
  input logic              cs_b,
  input logic              wr_n,
  input logic              oe_n,
  input logic              lane0_n,
  input logic              lane1_n,
  input logic              byte_mode_n,
  input logic [ADDR_W-1:0] addr,
  input logic [15:0]       dq_in,
  input logic [15:0]       dq_out,
  input logic [15:0]       dq_oe
);
  p_desel_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_a_n || !cs_b || (lane0_n && lane1_n)) |-> (dq_oe == 16'h0));

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_n && oe_n) |-> (dq_oe == 16'h0));

  p_write_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (dq_oe == 16'h0));

  p_word_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_mode_n && !cs_a_n && cs_b && wr_n && !oe_n)
      |-> (dq_oe == {{8{!lane1_n}}, {8{!lane0_n}}}));

  p_byte_upper_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_mode_n |-> (dq_oe[15:8] == 8'h0));

  p_byte_lane_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_mode_n && (lane0_n || lane1_n)) |-> (dq_oe == 16'h0));

  p_undriven_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((dq_out & ~dq_oe) == 16'h0));
endmodule

bind dwsram dwsram_check #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dwsram_test.sv
module dwsram_test;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_a_n = 1'b1, cs_b = 1'b0, wr_n = 1'b1, oe_n = 1'b1;
  logic          lane0_n = 1'b1, lane1_n = 1'b1, byte_mode_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0]   dq_in = '0;
  logic [15:0]   dq_out, dq_oe;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  dwsram #(.ADDR_W(AW)) uut (.*);

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    cs_a_n = 1'b1; cs_b = 1'b0; wr_n = 1'b1; oe_n = 1'b1;
    lane0_n = 1'b1; lane1_n = 1'b1; byte_mode_n = 1'b1; dq_in = '0;
  endtask

  // drive a write cycle; it commits on the following rising edge
  task automatic wr(logic [AW-1:0] a, logic [15:0] d, logic l0n, logic l1n,
                    logic bmn, logic csan, logic csb);
    @(negedge clk);
    cs_a_n = csan; cs_b = csb; wr_n = 1'b0; oe_n = 1'b0;
    lane0_n = l0n; lane1_n = l1n; byte_mode_n = bmn; addr = a; dq_in = d;
    #2 chk("R5 write oe", dq_oe, 16'h0);
  endtask

  task automatic rd(logic [AW-1:0] a, logic l0n, logic l1n, logic bmn,
                    logic hb, output logic [15:0] o, output logic [15:0] e);
    @(negedge clk);
    cs_a_n = 1'b0; cs_b = 1'b1; wr_n = 1'b1; oe_n = 1'b0;
    lane0_n = l0n; lane1_n = l1n; byte_mode_n = bmn; addr = a;
    dq_in = {hb, 15'h0};
    #2 o = dq_out; e = dq_oe;
  endtask

  task automatic t_reset();
    logic [15:0] o, e;
    #2 chk("R3 reset oe", dq_oe, 16'h0);
    chk("R9 reset out", dq_out, 16'h0);
    rst_n = 1'b1;
    idle();
    rd(3, 1, 1, 1, 0, o, e);
    chk("R3 both lanes off", e, 16'h0);
  endtask

  task automatic t_word();
    logic [15:0] o, e;
    wr(3, 16'hA5C3, 0, 0, 1, 0, 1);
    rd(3, 0, 0, 1, 0, o, e);
    chk("R1 full write", o, 16'hA5C3);
    chk("R2 full oe", e, 16'hFFFF);
    wr(3, 16'h1177, 1, 0, 1, 0, 1);
    rd(3, 0, 0, 1, 0, o, e);
    chk("R1 upper lane write", o, 16'h11C3);
    rd(3, 0, 1, 1, 0, o, e);
    chk("R2 lower only out", o, 16'h00C3);
    chk("R2 lower only oe", e, 16'h00FF);
    rd(3, 1, 0, 1, 0, o, e);
    chk("R9 upper only out", o, 16'h1100);
  endtask

  task automatic t_deselect();
    logic [15:0] o, e;
    wr(3, 16'hFFFF, 0, 0, 1, 1, 1);
    wr(3, 16'hEEEE, 0, 0, 1, 0, 0);
    wr(3, 16'hDDDD, 1, 1, 1, 0, 1);
    @(negedge clk);
    cs_a_n = 1'b1; cs_b = 1'b1; wr_n = 1'b1; oe_n = 1'b0;
    lane0_n = 1'b0; lane1_n = 1'b0;
    #2 chk("R3 cs_a off oe", dq_oe, 16'h0);
    rd(3, 0, 0, 1, 0, o, e);
    chk("R3 blocked writes", o, 16'h11C3);
    @(negedge clk);
    oe_n = 1'b1;
    #2 chk("R4 oe high", dq_oe, 16'h0);
  endtask

  task automatic t_byte();
    logic [15:0] o, e;
    rd(3, 0, 0, 0, 0, o, e);
    chk("R6 low half", o, 16'h00C3);
    chk("R6 oe low byte", e, 16'h00FF);
    rd(3, 0, 0, 0, 1, o, e);
    chk("R6 high half", o, 16'h0011);
    wr(3, 16'h805E, 0, 0, 0, 0, 1);
    wr(3, 16'h7F9A, 0, 0, 0, 0, 1);
    rd(3, 0, 0, 1, 0, o, e);
    chk("R6 byte writes", o, 16'h5E9A);
    rd(3, 0, 1, 0, 0, o, e);
    chk("R7 lane high oe", e, 16'h0);
    wr(3, 16'h0000, 1, 0, 0, 0, 1);
    rd(3, 0, 0, 1, 0, o, e);
    chk("R7 write blocked", o, 16'h5E9A);
  endtask

  task automatic t_timing();
    logic [15:0] o, e;
    wr(7, 16'h1234, 0, 0, 1, 0, 1);
    rd(7, 0, 0, 1, 0, o, e);
    chk("R8 read after write", o, 16'h1234);
    addr = 3;
    #2 chk("R8 addr change", dq_out, 16'h5E9A);
  endtask

  initial begin
    t_reset();
    t_word();
    t_deselect();
    t_byte();
    t_timing();
    idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule